// File: doc/BRIEF.md
# Dual-Clock Up/Down Binary Counter

This block is a presettable binary counter, four bits wide by default, that is stepped by two separate count-clock inputs. One input counts up and the other counts down. A rising edge on the up input adds one, but only while the down input is high. A rising edge on the down input subtracts one, but only while the up input is high. An active-high clear input forces the count to zero. An active-low load input copies the preset data into the count. The clear wins over the load, and both win over counting. The count wraps modulo 2^WIDTH in both directions.

Two active-low terminal outputs make it possible to chain stages. The carry output is low while the count is at its maximum and the up input is low. The borrow output is low while the count is zero and the down input is low. Both outputs are purely combinational, so each pulse lasts exactly as long as the low phase of the count clock it follows. Wire a stage's carry to the next stage's up input and its borrow to the next stage's down input. The chain then counts as one wider binary counter.

Everything runs on a single system clock with a synchronous active-low reset. The count inputs are sampled on that clock. A rising edge is a low sample followed by a high sample. When rising edges land on both count inputs in the same cycle, the count holds.

Top module: `dual_clk_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count becomes 0 and the load input has no effect. With the count at 0 and both count inputs high, `carry_n` and `borrow_n` are both 1.
- R2: When `load_n` is 0 and `clr` is 0 at a clock edge, the count takes the value of `preset_d` at that edge. While `load_n` stays 0, rising edges on the count inputs leave the count at the preset value.
- R3: When `clr` is 1 at a clock edge, the count becomes 0, even while `load_n` is 0 and count edges arrive.
- R4: A rising edge on `up_clk` while `dn_clk` is high increments the count. The new value appears after the second system clock edge following the rise.
- R5: A rising edge on `dn_clk` while `up_clk` is high decrements the count, with the same two-edge latency.
- R6: The count holds in two cases: rising edges arrive on both count inputs in the same sample, or a rising edge on `up_clk` is sampled while `dn_clk` is low.
- R7: Counting wraps: incrementing 2^WIDTH-1 gives 0, and decrementing 0 gives 2^WIDTH-1.
- R8: `carry_n` is 0 exactly when the count equals 2^WIDTH-1 and `up_clk` is 0. It changes in the same cycle as `up_clk`, with no register delay.
- R9: `borrow_n` is 0 exactly when the count equals 0 and `dn_clk` is 0. It changes in the same cycle as `dn_clk`, with no register delay.
- R10: Two stages chained as carry-to-up and borrow-to-down count as one binary counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Active-high clear to zero, highest functional priority |
| load_n | input | 1 | Active-low parallel load of `preset_d` |
| preset_d | input | WIDTH | Value copied into the count on load |
| up_clk | input | 1 | Count-up clock; its rising edge increments |
| dn_clk | input | 1 | Count-down clock; its rising edge decrements |
| count_q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry: count at maximum and `up_clk` low |
| borrow_n | output | 1 | Active-low borrow: count at zero and `dn_clk` low |

## Verification
Each result is due at a known point after the input that causes it:
- A load or clear shows on `count_q` after one system clock edge.
- A count-clock rise shows after two edges: one into the sampling register and one into the count register.
- Carry and borrow follow the count-clock level within the same cycle.

The bench changes inputs only on falling clock edges. It reads the count exactly two falling edges after raising a count clock and one falling edge after a load or clear. It reads the terminal outputs a fraction of a nanosecond after changing a count-clock level. A second stage chained to the first checks cascading, because its carry and borrow arrival must line up cycle for cycle with the low stage's wrap.

// File: rtl/dcc_pkg.sv
// Shared definitions for the dual-clock counter.
// Assumes: channel 0 is the up clock and channel 1 is the down clock.
package dcc_pkg;
    localparam int CH_UP = 0;
    localparam int CH_DN = 1;
    localparam int N_CH  = 2;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;
endpackage

// File: rtl/dcc_edge_det.sv
// Samples each count-clock input on the system clock and flags rising edges.
// A rise is a high sample whose previous sample was low. Both sample stages
// reset to 1 (the idle level), so reset never produces a false edge.
// Assumes: the inputs are synchronous to clk or already synchronised.
module dcc_edge_det #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl_in,
    output logic [NCH-1:0] lvl_s,
    output logic [NCH-1:0] rise
);
    logic [NCH-1:0] lvl_prev;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Two-stage sample history for one channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_s[g]    <= 1'b1;
                lvl_prev[g] <= 1'b1;
            end else begin
                lvl_s[g]    <= lvl_in[g];
                lvl_prev[g] <= lvl_s[g];
            end
        end

        // Rising edge flag for one channel
        always_comb rise[g] = lvl_s[g] & ~lvl_prev[g];

        // R4
        rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/dcc_step_sel.sv
// Chooses the count step from the sampled levels and edge flags.
// An up rise counts only while the down level is high. A down rise counts
// only while the up level is high. Simultaneous rises cancel.
module dcc_step_sel
    import dcc_pkg::*;
(
    input  logic [N_CH-1:0] lvl_s,
    input  logic [N_CH-1:0] rise,
    output step_e           step
);
    // Decode the step request
    always_comb begin
        step = STEP_HOLD;
        if (rise[CH_UP] && !rise[CH_DN] && lvl_s[CH_DN])
            step = STEP_INC;
        else if (rise[CH_DN] && !rise[CH_UP] && lvl_s[CH_UP])
            step = STEP_DEC;
    end
endmodule

// File: rtl/dcc_count_core.sv
// Count register. Priority order: system reset, clear, parallel load, step.
// Counting wraps modulo 2**WIDTH.
module dcc_count_core
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_d,
    input  step_e            step,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Update the count with the fixed priority order
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (!load_n)
            count <= preset_d;
        else if (step == STEP_INC)
            count <= count + ONE;
        else if (step == STEP_DEC)
            count <= count - ONE;
    end

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (count == $past(preset_d)));

    // R7
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n) |=> ((count == $past(count)) ||
                              (count == $past(count) + ONE) ||
                              (count == $past(count) - ONE)));
endmodule

// File: rtl/dcc_term_dec.sv
// Combinational active-low terminal outputs for cascading.
// Carry is low at the maximum count while the up clock is low. Borrow is low
// at zero while the down clock is low. The raw clock levels are used, so the
// pulses follow the count clocks with no register delay.
module dcc_term_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

    // Terminal count decode
    always_comb begin
        carry_n  = ~((count == MAX_VAL) & ~up_lvl);
        borrow_n = ~((count == '0) & ~dn_lvl);
    end
endmodule

// File: rtl/dual_clk_counter.sv
// Top of the dual-clock up/down counter: edge detection on the two count
// clocks, step selection, the count register and terminal decode.
// Assumes: one system clock, synchronous active-low reset, and count clocks
// that stay at each level for at least one system clock period.
module dual_clk_counter
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_d,
    input  logic             up_clk,
    input  logic             dn_clk,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

    logic [N_CH-1:0] clk_lvl;
    logic [N_CH-1:0] lvl_s;
    logic [N_CH-1:0] rise;
    step_e           step;

    // Pack the count clocks into channel order
    always_comb begin
        clk_lvl[CH_UP] = up_clk;
        clk_lvl[CH_DN] = dn_clk;
    end

    dcc_edge_det #(.NCH(N_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (clk_lvl),
        .lvl_s  (lvl_s),
        .rise   (rise)
    );

    dcc_step_sel u_sel (
        .lvl_s (lvl_s),
        .rise  (rise),
        .step  (step)
    );

    dcc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load_n   (load_n),
        .preset_d (preset_d),
        .step     (step),
        .count    (count_q)
    );

    dcc_term_dec #(.WIDTH(WIDTH)) u_term (
        .count    (count_q),
        .up_lvl   (up_clk),
        .dn_lvl   (dn_clk),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R6
    both_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[CH_UP] && rise[CH_DN] && load_n && !clr) |=> $stable(count_q));

    // R8
    carry_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count_q == MAX_VAL && !up_clk));

    // R9
    borrow_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count_q == '0 && !dn_clk));
endmodule

// File: tb/dual_clk_counter_tb.sv
module dual_clk_counter_tb;
    localparam int W   = 4;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic load_n = 1'b1;
    logic [W-1:0] preset_d = '0;
    logic up_clk = 1'b1;
    logic dn_clk = 1'b1;
    logic [W-1:0] count_q, hi_count;
    logic carry_n, borrow_n, hi_carry_n, hi_borrow_n;

    int n_checks = 0;
    int n_fail = 0;
    int exp_lo = 0;
    int exp_hi = 0;

    always #5 clk = ~clk;

    dual_clk_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .preset_d(preset_d), .up_clk(up_clk), .dn_clk(dn_clk),
        .count_q(count_q), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    // Second stage chained for R10
    dual_clk_counter #(.WIDTH(W)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .load_n(1'b1),
        .preset_d('0), .up_clk(carry_n), .dn_clk(borrow_n),
        .count_q(hi_count), .carry_n(hi_carry_n), .borrow_n(hi_borrow_n)
    );

    function automatic int wrap_inc(int v);
        return (v + 1) & MAX;
    endfunction

    function automatic int wrap_dec(int v);
        return (v - 1) & MAX;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(req, int'(count_q), exp_lo);
        chk("R10", int'(hi_count), exp_hi);
    endtask

    // Up pulse; 'counts' is 0 while load holds the count
    task automatic up_pulse(input bit counts);
        bit bump;
        @(negedge clk) up_clk = 1'b0;
        bump = (exp_lo == MAX);
        #1 chk("R8", int'(carry_n), bump ? 0 : 1);
        @(negedge clk) up_clk = 1'b1;
        #1 chk("R8", int'(carry_n), 1);
        @(negedge clk);
        @(negedge clk);
        if (counts) exp_lo = wrap_inc(exp_lo);
        if (bump) exp_hi = wrap_inc(exp_hi);
        chk_counts(counts ? "R4" : "R2");
    endtask

    task automatic dn_pulse();
        bit bump;
        @(negedge clk) dn_clk = 1'b0;
        bump = (exp_lo == 0);
        #1 chk("R9", int'(borrow_n), bump ? 0 : 1);
        @(negedge clk) dn_clk = 1'b1;
        #1 chk("R9", int'(borrow_n), 1);
        @(negedge clk);
        @(negedge clk);
        exp_lo = wrap_dec(exp_lo);
        if (bump) exp_hi = wrap_dec(exp_hi);
        chk_counts("R5");
    endtask

    task automatic both_pulse();
        @(negedge clk) begin up_clk = 1'b0; dn_clk = 1'b0; end
        #1 chk("R8", int'(carry_n), (exp_lo == MAX) ? 0 : 1);
        chk("R9", int'(borrow_n), (exp_lo == 0) ? 0 : 1);
        @(negedge clk) begin up_clk = 1'b1; dn_clk = 1'b1; end
        @(negedge clk);
        @(negedge clk);
        if (exp_lo == MAX) exp_hi = wrap_inc(exp_hi);
        if (exp_lo == 0) exp_hi = wrap_dec(exp_hi);
        chk_counts("R6");
    endtask

    // Up rise while down is low holds; releasing down then decrements
    task automatic blocked_up();
        @(negedge clk) dn_clk = 1'b0;
        @(negedge clk) up_clk = 1'b0;
        @(negedge clk) up_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (exp_lo == MAX) exp_hi = wrap_inc(exp_hi);
        chk_counts("R6");
        @(negedge clk) dn_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (exp_lo == 0) exp_hi = wrap_dec(exp_hi);
        exp_lo = wrap_dec(exp_lo);
        chk_counts("R5");
    endtask

    task automatic load_val(input int v, input bit with_pulse);
        @(negedge clk) begin load_n = 1'b0; preset_d = W'(v); end
        @(negedge clk);
        exp_lo = v;
        chk_counts("R2");
        if (with_pulse) up_pulse(1'b0);
        @(negedge clk) load_n = 1'b1;
        @(negedge clk);
        chk_counts("R2");
    endtask

    task automatic clear_now();
        @(negedge clk) begin clr = 1'b1; load_n = 1'b0; preset_d = W'($urandom); end
        @(negedge clk);
        exp_lo = 0;
        chk_counts("R3");
        clr = 1'b0;
        load_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0193));
        // R1: reset state, load ignored during reset
        repeat (3) @(negedge clk);
        chk("R1", int'(count_q), 0);
        chk("R1", int'(carry_n), 1);
        chk("R1", int'(borrow_n), 1);
        load_n = 1'b0;
        preset_d = 4'd9;
        @(negedge clk);
        chk("R1", int'(count_q), 0);
        load_n = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk_counts("R1");

        // Directed corners
        up_pulse(1'b1);          // R4: 0 -> 1
        dn_pulse();              // R5: 1 -> 0
        dn_pulse();              // R7: 0 -> 15, hi borrows
        chk("R7", int'(count_q), MAX);
        up_pulse(1'b1);          // R7: 15 -> 0, hi carries
        chk("R7", int'(count_q), 0);
        load_val(MAX, 1'b1);     // R2: load held, up edge ignored
        clear_now();             // R3: clear beats load
        both_pulse();            // R6
        load_val(MAX, 1'b0);
        both_pulse();            // R6 at max
        blocked_up();            // R6 at max
        clear_now();
        blocked_up();            // R6 at zero

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 7)
                0, 1: up_pulse(1'b1);
                2, 3: dn_pulse();
                4:    load_val(int'($urandom % (MAX + 1)), ($urandom % 2) == 1);
                5:    begin if (($urandom % 4) == 0) clear_now(); else both_pulse(); end
                default: blocked_up();
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule